// File: doc/BRIEF.md
# Output Driver Impedance Update Scheduler

This block decides when a freshly measured output-driver impedance code may replace the code that the drivers are using. An outside measurement circuit delivers a code with a valid pulse. The scheduler keeps that code as pending. It copies the code into the active code only in a cycle where the data bus is not being driven, and it marks that copy with a one-cycle strobe. Write and deselect cycles put the bus into high impedance, so each of them is a chance to apply a pending code. A stream of measurements keeps the impedance following supply and temperature drift.

After reset, the block waits a fixed number of running clock cycles before it reports ready. It makes no update before ready. It makes none while the device sleeps. It makes none while the clock-running indication is low. The active code leaves reset at mid-scale.

Top module: `zq_update_sched`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `active_code` equals mid-scale (only its top bit set), `upd_strobe` is 0 and `ready` is 0.
- R2: `ready` rises after exactly `WAIT_CYCLES` (default 4096) rising edges taken with reset low and `clk_run` high. Once high, it stays high until reset.
- R3: Edges taken while `clk_run` is low do not advance the power-up count.
- R4: `upd_strobe` and any change of `active_code` occur only at an edge where `bus_hiz` was 1.
- R5: No update is applied at an edge where `sleep` was 1.
- R6: No update is applied at an edge where `clk_run` was 0.
- R7: If several codes arrive before a qualifying edge, only the most recent one is applied.
- R8: A code that arrives before `ready` stays pending. It is applied at the first qualifying edge after `ready` is high.
- R9: An applied code raises `upd_strobe` for exactly one cycle and clears the pending state. A later qualifying edge with nothing pending raises no strobe.
- R10: When a new code arrives at a qualifying edge while an older code is pending, the older code is applied and the new code becomes pending.
- R11: `active_code` holds its value in every cycle where `upd_strobe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_hiz | input | 1 | Data bus is in high impedance this cycle (write or deselect) |
| sleep | input | 1 | Device is in sleep mode |
| clk_run | input | 1 | Clock-running indication |
| meas_valid | input | 1 | New measured code present |
| meas_code | input | CODE_W | Measured impedance code |
| upd_strobe | output | 1 | One-cycle pulse when the active code is updated |
| ready | output | 1 | Power-up wait complete |
| active_code | output | CODE_W | Impedance code in use by the drivers |

## Verification
A measurement can arrive in the same edge at which a qualifying high-Z window applies an older pending code. The bench sets this up by leaving one code pending and then presenting a second code in a high-Z, awake, clock-running cycle. The scoreboard expects the older code to be applied at that edge. It then expects the newer code at the next qualifying edge and no strobe after that. Every strobe is matched against the queue, and any strobe the queue did not predict counts as a failure.

// File: rtl/zq_pkg.sv
package zq_pkg;
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/zq_pwrup_timer.sv
module zq_pwrup_timer #(
  parameter int unsigned WAIT_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic clk_run,
  output logic ready
);
  localparam int unsigned CW = zq_pkg::cnt_width(WAIT_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (clk_run && !ready) begin
      cnt   <= cnt + 1'b1;
      ready <= (cnt == LAST);
    end
  end

  a_r2_ready_sticky: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);
  a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (!clk_run && !ready) |=> !ready);
endmodule

// File: rtl/zq_pending_reg.sv
module zq_pending_reg #(
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              meas_valid,
  input  logic [CODE_W-1:0] meas_code,
  input  logic              take,
  output logic              pend_v,
  output logic [CODE_W-1:0] pend_code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v    <= 1'b0;
      pend_code <= '0;
    end else begin
      if (meas_valid) begin
        pend_v    <= 1'b1;
        pend_code <= meas_code;
      end else if (take) begin
        pend_v <= 1'b0;
      end
    end
  end

  a_r7_latest_kept: assert property (@(posedge clk) disable iff (rst)
    meas_valid |=> (pend_v && pend_code == $past(meas_code)));
endmodule

// File: rtl/zq_window_qual.sv
module zq_window_qual (
  input  logic ready,
  input  logic bus_hiz,
  input  logic sleep,
  input  logic clk_run,
  output logic window
);
  always_comb window = ready && bus_hiz && !sleep && clk_run;
endmodule

// File: rtl/zq_update_sched.sv
module zq_update_sched #(
  parameter int unsigned CODE_W      = 6,
  parameter int unsigned WAIT_CYCLES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_hiz,
  input  logic              sleep,
  input  logic              clk_run,
  input  logic              meas_valid,
  input  logic [CODE_W-1:0] meas_code,
  output logic              upd_strobe,
  output logic              ready,
  output logic [CODE_W-1:0] active_code
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  logic              window;
  logic              take;
  logic              pend_v;
  logic [CODE_W-1:0] pend_code;

  zq_pwrup_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .clk_run(clk_run), .ready(ready)
  );

  zq_window_qual u_qual (
    .ready(ready), .bus_hiz(bus_hiz), .sleep(sleep),
    .clk_run(clk_run), .window(window)
  );

  assign take = window && pend_v;

  zq_pending_reg #(.CODE_W(CODE_W)) u_pend (
    .clk(clk), .rst(rst), .meas_valid(meas_valid), .meas_code(meas_code),
    .take(take), .pend_v(pend_v), .pend_code(pend_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_code <= MID;
      upd_strobe  <= 1'b0;
    end else begin
      upd_strobe <= take;
      if (take) active_code <= pend_code;
    end
  end

  a_r4_only_hiz: assert property (@(posedge clk) disable iff (rst)
    upd_strobe |-> $past(bus_hiz));
  a_r5_not_sleep: assert property (@(posedge clk) disable iff (rst)
    upd_strobe |-> !$past(sleep));
  a_r6_clock_running: assert property (@(posedge clk) disable iff (rst)
    upd_strobe |-> $past(clk_run));
  a_r8_after_ready: assert property (@(posedge clk) disable iff (rst)
    upd_strobe |-> $past(ready));
  a_r11_hold_code: assert property (@(posedge clk) disable iff (rst)
    !upd_strobe |-> $stable(active_code));
  a_r9_clears_pending: assert property (@(posedge clk) disable iff (rst)
    (take && !meas_valid) |=> !pend_v);
endmodule

// File: tb/tb_zq_update_sched.sv
`timescale 1ns/1ps
module tb_zq_update_sched;
  localparam int unsigned CODE_W = 6;
  localparam int unsigned WAIT_CYCLES = 4096;
  localparam logic [CODE_W-1:0] MID = 6'd32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_hiz = 1'b0, sleep = 1'b0, clk_run = 1'b1, meas_valid = 1'b0;
  logic [CODE_W-1:0] meas_code = '0;
  logic upd_strobe, ready;
  logic [CODE_W-1:0] active_code;

  int checks = 0;
  int errors = 0;

  logic [CODE_W-1:0] exp_q[$];
  logic [CODE_W-1:0] exp_active = MID;
  logic              m_pv = 1'b0;
  logic [CODE_W-1:0] m_pc = '0;
  logic              m_rdy = 1'b0;
  int                m_cnt = 0;

  always #2.5 clk = ~clk;

  zq_update_sched #(.CODE_W(CODE_W), .WAIT_CYCLES(WAIT_CYCLES)) dut (
    .clk(clk), .rst(rst), .bus_hiz(bus_hiz), .sleep(sleep), .clk_run(clk_run),
    .meas_valid(meas_valid), .meas_code(meas_code),
    .upd_strobe(upd_strobe), .ready(ready), .active_code(active_code)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, updating the reference model.
  task automatic cyc(input bit hiz, input bit slp, input bit run,
                     input bit mv, input logic [CODE_W-1:0] mc);
    bit win;
    @(negedge clk);
    bus_hiz = hiz; sleep = slp; clk_run = run; meas_valid = mv; meas_code = mc;
    win = m_rdy && hiz && !slp && run;
    if (win && m_pv) begin
      exp_q.push_back(m_pc);
      m_pv = 1'b0;
    end
    if (mv) begin
      m_pc = mc;
      m_pv = 1'b1;
    end
    @(posedge clk);
    if (run && !m_rdy) begin
      m_cnt++;
      if (m_cnt == WAIT_CYCLES) m_rdy = 1'b1;
    end
  endtask

  // Monitor: compare strobes against the scoreboard queue.
  always @(posedge clk) begin
    #1;
    if (!rst) begin
      if (upd_strobe) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4/R5/R6/R9 unexpected strobe", int'(active_code), -1);
        end else begin
          exp_active = exp_q.pop_front();
          check(active_code == exp_active, "R7/R10 applied code",
                int'(active_code), int'(exp_active));
        end
      end else begin
        if (exp_q.size() != 0) begin
          check(1'b0, "R8/R10 missing strobe", 0, int'(exp_q[0]));
          void'(exp_q.pop_front());
        end
        if (active_code != exp_active)
          check(1'b0, "R11 code changed without strobe",
                int'(active_code), int'(exp_active));
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(active_code == MID && !upd_strobe && !ready, "R1 reset state",
          int'(active_code), int'(MID));
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check(active_code == MID && !upd_strobe && !ready, "R1 first cycle after reset",
          int'(ready), 0);
    m_cnt = 1;

    // R3: stopped clock does not advance the count; R8: early code stays pending
    for (int i = 0; i < 50; i++) cyc(1'b1, 1'b0, 1'b0, i == 3, 6'd5);
    for (int i = 0; i < WAIT_CYCLES - 2; i++) cyc(1'b1, 1'b0, 1'b1, 1'b0, '0);
    #1;
    check(ready == 1'b0, "R3 count held while clock stopped", int'(ready), 0);
    check(active_code == MID, "R8 no update before ready", int'(active_code), int'(MID));
    cyc(1'b0, 1'b0, 1'b1, 1'b0, '0);
    #1;
    check(ready == 1'b1, "R2 ready after WAIT_CYCLES", int'(ready), 1);

    // R8: first qualifying edge applies the early code
    cyc(1'b1, 1'b0, 1'b1, 1'b0, '0);
    #2;
    check(active_code == 6'd5, "R8 early code applied", int'(active_code), 5);

    // R4: bus driven, no update
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 6'd9);
    repeat (4) cyc(1'b0, 1'b0, 1'b1, 1'b0, '0);
    #2;
    check(active_code == 6'd5, "R4 no update while driven", int'(active_code), 5);
    // R5: sleep blocks
    repeat (4) cyc(1'b1, 1'b1, 1'b1, 1'b0, '0);
    #2;
    check(active_code == 6'd5, "R5 no update in sleep", int'(active_code), 5);
    // R6: stopped clock blocks
    repeat (4) cyc(1'b1, 1'b0, 1'b0, 1'b0, '0);
    #2;
    check(active_code == 6'd5, "R6 no update with clock stopped", int'(active_code), 5);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, '0);
    #2;
    check(active_code == 6'd9, "R4 pending applied at high-Z", int'(active_code), 9);

    // R7: latest of several wins
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 6'd12);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 6'd20);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, '0);
    #2;
    check(active_code == 6'd20, "R7 latest code applied", int'(active_code), 20);
    // R9: strobe one cycle, nothing pending afterwards
    cyc(1'b1, 1'b0, 1'b1, 1'b0, '0);
    #2;
    check(upd_strobe == 1'b0, "R9 strobe lasts one cycle", int'(upd_strobe), 0);
    repeat (3) cyc(1'b1, 1'b0, 1'b1, 1'b0, '0);
    #2;
    check(active_code == 6'd20, "R9 no reapply", int'(active_code), 20);

    // R10: collision of arrival and window
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 6'd33);
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 6'd7);
    #2;
    check(active_code == 6'd33, "R10 older code applied first", int'(active_code), 33);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, '0);
    #2;
    check(active_code == 6'd7, "R10 newer code applied next", int'(active_code), 7);
    repeat (3) cyc(1'b1, 1'b0, 1'b1, 1'b0, '0);
    #2;
    check(ready == 1'b1, "R2 ready stays high", int'(ready), 1);
    check(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule